// File: doc/BRIEF.md
# Instruction Prefix and Register Selector

This block sits in the decode stage of a small 16-register processor and watches the instruction byte stream one byte at a time. Some bytes are prefixes. They do not execute. Instead they change how the next real instruction behaves. Alternate-mode prefixes select one of four opcode variants. Register-select prefixes pick the source register, the destination register, or both. The block keeps this pending context in registers and reports it on three status outputs.

When a byte that is not a prefix arrives, the block emits a one-cycle consume pulse on the next clock edge. The pulse carries the opcode, the accumulated alternate mode, and the chosen source and destination indices. On the same edge the block drops all pending context, so the following instruction starts from register 0 with no alternate mode.

After a select-both prefix, a destination-select or source-select byte is not treated as another prefix. It is a register-to-register move, and the block reports it as a consumed instruction of the move kind.

Top module: `prefix_select`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all pending context. After that edge, `cons_valid`, `st_alt1`, `st_alt2` and `st_b` are 0, and the next instruction sees alternate mode 0 and registers 0/0.
- R2: Byte 0x3D sets the ALT1 bit and byte 0x3E sets the ALT2 bit. Byte 0x3F sets both. These bits accumulate across prefixes and appear on `st_alt1` and `st_alt2` after the edge that accepts the byte.
- R3: Byte 0x1n selects Rn as the destination. Byte 0xBn selects Rn as the source. Neither produces a consume pulse while the select-both flag is clear.
- R4: Byte 0x2n selects Rn as both source and destination and raises `st_b`.
- R5: Prefixes do not clear one another. A later select of the same field replaces the earlier one, and every other pending field is kept.
- R6: A byte that is not a prefix produces `cons_valid` high for exactly the cycle after the edge that accepts it. In that cycle, `cons_op` is the byte and `cons_kind` is 0 (plain). `cons_alt` is the pending mode, with bit 0 = ALT1 and bit 1 = ALT2. `cons_src` and `cons_dst` are the pending indices.
- R7: While `st_b` is high, byte 0x1m is consumed as a move with `cons_kind` = 1, `cons_src` = n from the select-both prefix, and `cons_dst` = m.
- R8: While `st_b` is high, byte 0xBm is consumed as a flag-setting move with `cons_kind` = 2, `cons_src` = m, and `cons_dst` = n.
- R9: Every consumed instruction (R6, R7, R8) clears the alternate mode and the B flag and returns both selections to R0. This takes effect on the same edge that raises `cons_valid`.
- R10: A cycle with `in_valid` low changes no pending context and produces no consume pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_byte` holds an instruction byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| cons_valid | output | 1 | One-cycle pulse: an instruction was consumed |
| cons_op | output | 8 | Opcode byte of the consumed instruction |
| cons_kind | output | 2 | 0 plain, 1 move, 2 move with flags |
| cons_alt | output | 2 | Alternate mode in effect (bit0 ALT1, bit1 ALT2) |
| cons_src | output | 4 | Source register index |
| cons_dst | output | 4 | Destination register index |
| st_alt1 | output | 1 | Pending ALT1 status bit |
| st_alt2 | output | 1 | Pending ALT2 status bit |
| st_b | output | 1 | Select-both flag status bit |

## Verification
The assertions assume that `rst` is held high for at least one edge before any byte arrives. They also assume that `in_valid` and `in_byte` are known and stable at each sampling edge, because every property reads them as the cause of the next cycle's outputs. The bench changes inputs only on the falling clock edge, presents at most one byte per cycle, and begins with a reset. This keeps every observed byte within those assumptions. Idle gaps and a reset in the middle of a prefix run are driven on purpose, so the hold and clear properties see their antecedents.

// File: rtl/prefix_pkg.sv
package prefix_pkg;

    localparam int NREG  = 16;
    localparam int IDX_W = $clog2(NREG);
    localparam int OP_W  = 8;

    localparam logic [OP_W-1:0] OP_ALT_BASE = 8'h3C;
    localparam logic [3:0]      NIB_DST     = 4'h1;
    localparam logic [3:0]      NIB_BOTH    = 4'h2;
    localparam logic [3:0]      NIB_SRC     = 4'hB;

    typedef enum logic [2:0] {
        CLS_ALT,
        CLS_DST,
        CLS_SRC,
        CLS_BOTH,
        CLS_OTHER
    } cls_e;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_MOVE  = 2'd1,
        KIND_MOVES = 2'd2
    } kind_e;

    typedef struct packed {
        logic [1:0]       alt;
        logic             both;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
    } pend_t;

    typedef struct packed {
        logic             valid;
        logic [OP_W-1:0]  op;
        kind_e            kind;
        logic [1:0]       alt;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
    } cons_t;

endpackage

// File: rtl/prefix_classify.sv
module prefix_classify
    import prefix_pkg::*;
(
    input  logic [OP_W-1:0]  byte_i,
    output cls_e             cls_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [1:0]       alt_o
);

    logic [3:0] hi_nib;

    always_comb begin
        hi_nib = byte_i[OP_W-1 -: 4];
        idx_o  = byte_i[IDX_W-1:0];
        alt_o  = byte_i[1:0];
        if (byte_i[OP_W-1:2] == OP_ALT_BASE[OP_W-1:2] && byte_i[1:0] != 2'b00) begin
            cls_o = CLS_ALT;
        end else if (hi_nib == NIB_DST) begin
            cls_o = CLS_DST;
        end else if (hi_nib == NIB_SRC) begin
            cls_o = CLS_SRC;
        end else if (hi_nib == NIB_BOTH) begin
            cls_o = CLS_BOTH;
        end else begin
            cls_o = CLS_OTHER;
        end
    end

endmodule

// File: rtl/prefix_state.sv
module prefix_state
    import prefix_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_i,
    input  cls_e             cls_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [1:0]       alt_i,
    output pend_t            pend_q,
    output cons_t            cons_q
);

    typedef struct packed {
        pend_t pend;
        cons_t cons;
    } regs_t;

    regs_t r_d;
    regs_t r_q;
    logic  take;

    always_comb begin
        r_d            = r_q;
        r_d.cons.valid = 1'b0;
        take           = 1'b0;
        if (in_valid) begin
            r_d.cons.op   = op_i;
            r_d.cons.alt  = r_q.pend.alt;
            r_d.cons.src  = r_q.pend.src;
            r_d.cons.dst  = r_q.pend.dst;
            r_d.cons.kind = KIND_PLAIN;
            unique case (cls_i)
                CLS_ALT: begin
                    r_d.pend.alt = r_q.pend.alt | alt_i;
                end
                CLS_DST: begin
                    if (r_q.pend.both) begin
                        take          = 1'b1;
                        r_d.cons.kind = KIND_MOVE;
                        r_d.cons.dst  = idx_i;
                    end else begin
                        r_d.pend.dst = idx_i;
                    end
                end
                CLS_SRC: begin
                    if (r_q.pend.both) begin
                        take          = 1'b1;
                        r_d.cons.kind = KIND_MOVES;
                        r_d.cons.src  = idx_i;
                    end else begin
                        r_d.pend.src = idx_i;
                    end
                end
                CLS_BOTH: begin
                    r_d.pend.src  = idx_i;
                    r_d.pend.dst  = idx_i;
                    r_d.pend.both = 1'b1;
                end
                default: begin
                    take = 1'b1;
                end
            endcase
            if (take) begin
                r_d.cons.valid = 1'b1;
                r_d.pend       = '0;
            end else begin
                r_d.cons.op   = r_q.cons.op;
                r_d.cons.alt  = r_q.cons.alt;
                r_d.cons.src  = r_q.cons.src;
                r_d.cons.dst  = r_q.cons.dst;
                r_d.cons.kind = r_q.cons.kind;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend_q = r_q.pend;
    assign cons_q = r_q.cons;

endmodule

// File: rtl/prefix_select.sv
module prefix_select
    import prefix_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             cons_valid,
    output logic [7:0]       cons_op,
    output logic [1:0]       cons_kind,
    output logic [1:0]       cons_alt,
    output logic [3:0]       cons_src,
    output logic [3:0]       cons_dst,
    output logic             st_alt1,
    output logic             st_alt2,
    output logic             st_b
);

    cls_e             cls;
    logic [IDX_W-1:0] idx;
    logic [1:0]       alt_bits;
    pend_t            pend;
    cons_t            cons;

    prefix_classify u_cls (
        .byte_i (in_byte),
        .cls_o  (cls),
        .idx_o  (idx),
        .alt_o  (alt_bits)
    );

    prefix_state u_state (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .op_i     (in_byte),
        .cls_i    (cls),
        .idx_i    (idx),
        .alt_i    (alt_bits),
        .pend_q   (pend),
        .cons_q   (cons)
    );

    assign cons_valid = cons.valid;
    assign cons_op    = cons.op;
    assign cons_kind  = cons.kind;
    assign cons_alt   = cons.alt;
    assign cons_src   = cons.src;
    assign cons_dst   = cons.dst;
    assign st_alt1    = pend.alt[0];
    assign st_alt2    = pend.alt[1];
    assign st_b       = pend.both;

endmodule

// File: rtl/prefix_select_chk.sv
module prefix_select_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       cons_valid,
    input logic [1:0] cons_kind,
    input logic       st_alt1,
    input logic       st_alt2,
    input logic       st_b
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!cons_valid && !st_alt1 && !st_alt2 && !st_b));

    a_r2_alt1_sets: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte == 8'h3D) |=> st_alt1);

    a_r4_both_raises_b: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte[7:4] == 4'h2) |=> st_b);

    a_r6_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
        cons_valid |-> $past(in_valid));

    a_r7_move_after_b: assert property (@(posedge clk) disable iff (rst)
        (in_valid && st_b && in_byte[7:4] == 4'h1) |=> (cons_valid && cons_kind == 2'd1));

    a_r8_moves_after_b: assert property (@(posedge clk) disable iff (rst)
        (in_valid && st_b && in_byte[7:4] == 4'hB) |=> (cons_valid && cons_kind == 2'd2));

    a_r9_consume_clears: assert property (@(posedge clk) disable iff (rst)
        cons_valid |-> (!st_alt1 && !st_alt2 && !st_b));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!cons_valid && $stable({st_alt1, st_alt2, st_b})));

endmodule

bind prefix_select prefix_select_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .cons_valid (cons_valid),
    .cons_kind  (cons_kind),
    .st_alt1    (st_alt1),
    .st_alt2    (st_alt2),
    .st_b       (st_b)
);

// File: tb/tb_prefix_select.sv
module tb_prefix_select;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       cons_valid;
    logic [7:0] cons_op;
    logic [1:0] cons_kind;
    logic [1:0] cons_alt;
    logic [3:0] cons_src;
    logic [3:0] cons_dst;
    logic       st_alt1;
    logic       st_alt2;
    logic       st_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    prefix_select dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .cons_valid (cons_valid),
        .cons_op    (cons_op),
        .cons_kind  (cons_kind),
        .cons_alt   (cons_alt),
        .cons_src   (cons_src),
        .cons_dst   (cons_dst),
        .st_alt1    (st_alt1),
        .st_alt2    (st_alt2),
        .st_b       (st_b)
    );

    // vector: byte, valid, kind, alt, src, dst, {alt1, alt2, b}
    localparam int NV = 20;
    localparam logic [23:0] VEC [NV] = '{
        {8'h55, 1'b1, 2'd0, 2'd0, 4'd0,  4'd0,  3'b000}, // R6 plain
        {8'h3D, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b100}, // R2
        {8'h13, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b100}, // R3 R5
        {8'hB7, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b100}, // R3 R5
        {8'h5A, 1'b1, 2'd0, 2'd1, 4'd7,  4'd3,  3'b000}, // R6 R9
        {8'h3E, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b010}, // R2
        {8'h3D, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b110}, // R2 accumulate
        {8'h4C, 1'b1, 2'd0, 2'd3, 4'd0,  4'd0,  3'b000}, // R6
        {8'h24, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b001}, // R4
        {8'h19, 1'b1, 2'd1, 2'd0, 4'd4,  4'd9,  3'b000}, // R7
        {8'h26, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b001}, // R4
        {8'hB2, 1'b1, 2'd2, 2'd0, 4'd2,  4'd6,  3'b000}, // R8
        {8'h3F, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b110}, // R2
        {8'h21, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b111}, // R4 R5
        {8'h3C, 1'b1, 2'd0, 2'd3, 4'd1,  4'd1,  3'b000}, // R6
        {8'h1E, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b000}, // R3
        {8'h2A, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b001}, // R5 override
        {8'h2B, 1'b0, 2'd0, 2'd0, 4'd0,  4'd0,  3'b001}, // R5 override
        {8'h00, 1'b1, 2'd0, 2'd0, 4'd11, 4'd11, 3'b000}, // R6
        {8'h60, 1'b1, 2'd0, 2'd0, 4'd0,  4'd0,  3'b000}  // R9 defaults
    };

    task automatic report(input string req, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [23:0] observe(input logic [7:0] b, input logic with_fields);
        if (with_fields)
            return {b, cons_valid, cons_kind, cons_alt, cons_src, cons_dst, st_alt1, st_alt2, st_b};
        return {b, cons_valid, 2'd0, 2'd0, 4'd0, 4'd0, st_alt1, st_alt2, st_b};
    endfunction

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected at most 5000", cycles);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        report("R1", {cons_valid, st_alt1, st_alt2, st_b}, 24'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] e;
            e = VEC[i];
            send(e[23:16]);
            if (e[15])
                report("R6/R7/R8/R9 vector", observe(e[23:16], 1'b1), e);
            else
                report("R2/R3/R4/R5 vector", observe(e[23:16], 1'b0), e);
        end

        // R6 single-cycle pulse: after a consume with no new byte, valid drops
        send(8'h70);
        idle(1);
        report("R6 pulse width", {23'd0, cons_valid}, 24'd0);

        // R10 idle gaps hold pending context and give no pulse
        send(8'h3E);
        send(8'h15);
        idle(3);
        report("R10 hold", {cons_valid, st_alt1, st_alt2, st_b}, {1'b0, 3'b010});
        send(8'h80);
        report("R10 after idle", {cons_valid, cons_op, cons_alt, cons_dst},
               {1'b1, 8'h80, 2'd2, 4'd5});

        // R1 reset in the middle of a prefix run
        send(8'h3D);
        send(8'h25);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        report("R1 mid-run reset", {cons_valid, st_alt1, st_alt2, st_b}, 24'h0);
        send(8'h70);
        report("R1 defaults after reset", {cons_valid, cons_kind, cons_alt, cons_src, cons_dst},
               {1'b1, 2'd0, 2'd0, 4'd0, 4'd0});

        // R7 move keeps pending alt mode in the consumed instruction, then R9 clears it
        send(8'h3E);
        send(8'h2F);
        send(8'h10);
        report("R7 move with alt", {cons_valid, cons_kind, cons_alt, cons_src, cons_dst, st_alt2, st_b},
               {1'b1, 2'd1, 2'd2, 4'd15, 4'd0, 1'b0, 1'b0});

        finish_run();
    end

endmodule